// File: doc/BRIEF.md
# Fail-safe operating mode sequencer

This block is the supervisory state machine of a system basis controller. It tracks which operating mode the controller is in (start-up, normal, reprogramming, or fail-safe) and decides when to issue a system reset. Each system reset comes with a 4-bit code that records its cause. Software steers the block by writing 3-bit mode codes through a register strobe. A separate watchdog supplies a flag that says whether the current write lands inside its legal window, and it also signals an overflow.

The reprogramming (flash) mode is guarded. The only way in is a run of three back-to-back in-window writes made from normal mode. That run ends in a system reset. After the reset, software completes a single handshake from start-up mode. Once in flash mode, any code other than the watchdog service code or the clean-exit code forces a reset. An oscillator-fault flag overrides everything and parks the block in fail-safe mode. The block leaves fail-safe mode only when the oscillator is healthy again and a wake-up event arrives.

All outputs are registered. The mode and the reset source change on the clock edge that samples the causing input, and the reset pulse is high for the one cycle after that edge.

Top module: `fs_mode_seq`

## Requirements
- R1: While reset is asserted and right after it is released, mode_o is start-up (00), rst_pulse_o is 0 and rst_src_o is 0000. The other mode encodings are normal 01, flash 10 and fail-safe 11.
- R2: In normal mode, three consecutive writes of 111, then 001, then 111, each with wd_legal_i high, move the block to start-up. This also gives a reset pulse with source 0110 and arms one flash handshake.
- R3: During the entry run, a write whose code does not match the expected step, or any write with wd_legal_i low, returns the tracker to idle. Only a fresh in-window 111 starts a new run.
- R4: In start-up with the handshake armed, a write of 011 enters flash mode without a reset, and it consumes the arming. A later 011 in start-up is ignored.
- R5: In start-up, a write of 101 enters normal mode without a reset and clears the arming.
- R6: In start-up, writes other than 101 and armed 011 change neither the mode nor the reset outputs.
- R7: If start-up lasts INIT_CYCLES cycles with no accepted handshake, the block gives a reset pulse with source 1000, stays in start-up and clears the arming.
- R8: In flash mode, an in-window 111 keeps the mode. A 111 outside the window, or a wd_overflow_i pulse, gives a reset with source 0011 and returns to start-up. wd_overflow_i has no effect outside flash mode.
- R9: In flash mode, a write of 110 gives a reset with source 0111 and returns to start-up.
- R10: In flash mode, a write of any code other than 111 or 110 gives a reset with source 0101 and returns to start-up.
- R11: osc_fault_i high moves the block to fail-safe on the next edge from any mode. This move gives no reset pulse and clears both the entry tracker and the arming.
- R12: Fail-safe mode is left only on an edge where wake_i is high and osc_fault_i is low. The block then moves to start-up with a reset pulse and source 1001.
- R13: rst_pulse_o is never high for two cycles in a row. rst_src_o changes only together with a reset pulse and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Mode register write strobe |
| wr_code_i | input | 3 | Mode code carried by the write |
| wd_legal_i | input | 1 | Current write lies inside the legal watchdog window |
| wd_overflow_i | input | 1 | Watchdog overflow event |
| osc_fault_i | input | 1 | Oscillator too slow or stopped |
| wake_i | input | 1 | Wake-up event |
| mode_o | output | 2 | Current operating mode |
| rst_pulse_o | output | 1 | One-cycle system reset request |
| rst_src_o | output | 4 | Cause of the most recent reset |

## Verification
Some properties are checked on every cycle:
- the reset pulse is one cycle wide, and the source code holds between pulses;
- an oscillator fault forces fail-safe without a pulse;
- flash mode is entered only from start-up;
- every entry into start-up comes with a pulse;
- fail-safe is left only on a wake-up with the oscillator healthy.

Other behaviour can only be shown by the bench's scenarios:
- the exact code order of the entry run, and the tracker falling back to idle on a mismatch or an out-of-window write;
- the handshake being usable only once;
- the count that sets the start-up timeout;
- the choice among the distinct reset-source codes.

// File: rtl/fs_seq_pkg.sv
package fs_seq_pkg;
  localparam int CODE_W = 3;
  localparam int SRC_W  = 4;

  typedef enum logic [1:0] {
    M_STARTUP  = 2'b00,
    M_NORMAL   = 2'b01,
    M_FLASH    = 2'b10,
    M_FAILSAFE = 2'b11
  } mode_e;

  localparam logic [CODE_W-1:0] C_STEP_ODD  = 3'b111;
  localparam logic [CODE_W-1:0] C_STEP_EVEN = 3'b001;
  localparam logic [CODE_W-1:0] C_HS_FLASH  = 3'b011;
  localparam logic [CODE_W-1:0] C_HS_NORMAL = 3'b101;
  localparam logic [CODE_W-1:0] C_LEAVE     = 3'b110;
  localparam logic [CODE_W-1:0] C_SERVE     = 3'b111;

  localparam logic [SRC_W-1:0] S_NONE     = 4'b0000;
  localparam logic [SRC_W-1:0] S_WDOG     = 4'b0011;
  localparam logic [SRC_W-1:0] S_ILLEGAL  = 4'b0101;
  localparam logic [SRC_W-1:0] S_ENTRY    = 4'b0110;
  localparam logic [SRC_W-1:0] S_EXIT     = 4'b0111;
  localparam logic [SRC_W-1:0] S_INIT_TMO = 4'b1000;
  localparam logic [SRC_W-1:0] S_WAKE     = 4'b1001;
endpackage

// File: rtl/fs_entry_tracker.sv
module fs_entry_tracker
  import fs_seq_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              legal_i,
  output logic              done_o
);
  localparam int STG_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [STG_W-1:0] LAST = STG_W'(STEPS - 1);

  logic [STG_W-1:0]  stage_q;
  logic [CODE_W-1:0] exp_code;
  logic              hit;

  // steps alternate 111 / 001 starting with 111
  assign exp_code = stage_q[0] ? C_STEP_EVEN : C_STEP_ODD;
  assign hit      = wr_i && legal_i && (code_i == exp_code);
  assign done_o   = en_i && hit && (stage_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 stage_q <= '0;
    else if (!en_i)              stage_q <= '0;
    else if (wr_i) begin
      if (hit && stage_q != LAST) stage_q <= stage_q + 1'b1;
      else                        stage_q <= '0;
    end
  end
endmodule

// File: rtl/fs_init_timer.sv
module fs_init_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || clr_i) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fs_mode_seq.sv
module fs_mode_seq
  import fs_seq_pkg::*;
#(
  parameter int INIT_CYCLES = 64,
  parameter int ENTRY_STEPS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              wd_legal_i,
  input  logic              wd_overflow_i,
  input  logic              osc_fault_i,
  input  logic              wake_i,
  output logic [1:0]        mode_o,
  output logic              rst_pulse_o,
  output logic [SRC_W-1:0]  rst_src_o
);
  mode_e             mode_q, mode_d;
  logic              arm_q, arm_d;
  logic              pulse_q, pulse_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic              seq_done, tmo;

  fs_entry_tracker #(.STEPS(ENTRY_STEPS)) u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (mode_q == M_NORMAL && !osc_fault_i),
    .wr_i    (wr_valid_i),
    .code_i  (wr_code_i),
    .legal_i (wd_legal_i),
    .done_o  (seq_done)
  );

  fs_init_timer #(.CYCLES(INIT_CYCLES)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (mode_q == M_STARTUP && !osc_fault_i),
    .clr_i     (tmo),
    .expired_o (tmo)
  );

  always_comb begin
    mode_d  = mode_q;
    arm_d   = arm_q;
    pulse_d = 1'b0;
    src_d   = src_q;
    if (osc_fault_i) begin
      mode_d = M_FAILSAFE;
      arm_d  = 1'b0;
    end else begin
      unique case (mode_q)
        M_STARTUP: begin
          if (wr_valid_i && wr_code_i == C_HS_NORMAL) begin
            mode_d = M_NORMAL;
            arm_d  = 1'b0;
          end else if (wr_valid_i && wr_code_i == C_HS_FLASH && arm_q) begin
            mode_d = M_FLASH;
            arm_d  = 1'b0;
          end else if (tmo) begin
            pulse_d = 1'b1;
            src_d   = S_INIT_TMO;
            arm_d   = 1'b0;
          end
        end
        M_NORMAL: begin
          if (seq_done) begin
            mode_d  = M_STARTUP;
            pulse_d = 1'b1;
            src_d   = S_ENTRY;
            arm_d   = 1'b1;
          end
        end
        M_FLASH: begin
          if (wd_overflow_i) begin
            mode_d  = M_STARTUP;
            pulse_d = 1'b1;
            src_d   = S_WDOG;
          end else if (wr_valid_i) begin
            if (wr_code_i == C_SERVE) begin
              if (!wd_legal_i) begin
                mode_d  = M_STARTUP;
                pulse_d = 1'b1;
                src_d   = S_WDOG;
              end
            end else begin
              mode_d  = M_STARTUP;
              pulse_d = 1'b1;
              src_d   = (wr_code_i == C_LEAVE) ? S_EXIT : S_ILLEGAL;
            end
          end
        end
        M_FAILSAFE: begin
          if (wake_i) begin
            mode_d  = M_STARTUP;
            pulse_d = 1'b1;
            src_d   = S_WAKE;
          end
        end
        default: mode_d = M_FAILSAFE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_STARTUP;
      arm_q   <= 1'b0;
      pulse_q <= 1'b0;
      src_q   <= S_NONE;
    end else begin
      mode_q  <= mode_d;
      arm_q   <= arm_d;
      pulse_q <= pulse_d;
      src_q   <= src_d;
    end
  end

  assign mode_o      = mode_q;
  assign rst_pulse_o = pulse_q;
  assign rst_src_o   = src_q;
endmodule

// File: rtl/fs_mode_seq_chk.sv
module fs_mode_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       osc_fault_i,
  input logic       wake_i,
  input logic [1:0] mode_o,
  input logic       rst_pulse_o,
  input logic [3:0] rst_src_o
);
  localparam logic [1:0] MS = 2'b00, MF = 2'b10, MX = 2'b11;

  p_pulse_one_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |=> !rst_pulse_o);

  p_src_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_pulse_o |-> $stable(rst_src_o));

  p_osc_fs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fault_i |=> (mode_o == MX && !rst_pulse_o));

  p_flash_from_startup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MF && $past(mode_o) != MF) |-> $past(mode_o) == MS);

  p_startup_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MS && $past(mode_o) != MS) |-> rst_pulse_o);

  p_fs_exit_wake_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_o) == MX && mode_o != MX) |-> $past(wake_i && !osc_fault_i));
endmodule

bind fs_mode_seq fs_mode_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .osc_fault_i (osc_fault_i),
  .wake_i      (wake_i),
  .mode_o      (mode_o),
  .rst_pulse_o (rst_pulse_o),
  .rst_src_o   (rst_src_o)
);

// File: tb/fs_mode_seq_test.sv
module fs_mode_seq_test;
  localparam int INIT = 16;
  localparam logic [1:0] MS = 2'b00, MN = 2'b01, MF = 2'b10, MX = 2'b11;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid = 1'b0, wd_legal = 1'b0, wd_ovf = 1'b0, osc_fault = 1'b0, wake = 1'b0;
  logic [2:0] wr_code = '0;
  logic [1:0] mode;
  logic pulse;
  logic [3:0] src;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  fs_mode_seq #(.INIT_CYCLES(INIT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid), .wr_code_i(wr_code),
    .wd_legal_i(wd_legal), .wd_overflow_i(wd_ovf), .osc_fault_i(osc_fault),
    .wake_i(wake), .mode_o(mode), .rst_pulse_o(pulse), .rst_src_o(src)
  );

  // {code, legal, exp_mode, exp_pulse, exp_src}
  localparam int NV = 32;
  localparam logic [10:0] VEC [NV] = '{
    {3'b101,1'b1,MN,1'b0,4'h0},  // R5
    {3'b111,1'b1,MN,1'b0,4'h0},  // R2
    {3'b001,1'b1,MN,1'b0,4'h0},  // R2
    {3'b111,1'b1,MS,1'b1,4'h6},  // R2
    {3'b011,1'b1,MF,1'b0,4'h6},  // R4
    {3'b111,1'b1,MF,1'b0,4'h6},  // R8 serve
    {3'b110,1'b1,MS,1'b1,4'h7},  // R9
    {3'b011,1'b1,MS,1'b0,4'h7},  // R4 R6 not armed
    {3'b101,1'b1,MN,1'b0,4'h7},  // R5
    {3'b111,1'b1,MN,1'b0,4'h7},  // R3
    {3'b001,1'b0,MN,1'b0,4'h7},  // R3 out of window
    {3'b001,1'b1,MN,1'b0,4'h7},  // R3 idle
    {3'b111,1'b1,MN,1'b0,4'h7},
    {3'b001,1'b1,MN,1'b0,4'h7},
    {3'b111,1'b1,MS,1'b1,4'h6},  // R2
    {3'b101,1'b1,MN,1'b0,4'h6},  // R5
    {3'b111,1'b1,MN,1'b0,4'h6},
    {3'b001,1'b1,MN,1'b0,4'h6},
    {3'b111,1'b1,MS,1'b1,4'h6},  // R2
    {3'b011,1'b1,MF,1'b0,4'h6},  // R4
    {3'b010,1'b1,MS,1'b1,4'h5},  // R10
    {3'b011,1'b1,MS,1'b0,4'h5},  // R4 once only
    {3'b101,1'b1,MN,1'b0,4'h5},
    {3'b111,1'b1,MN,1'b0,4'h5},  // R3
    {3'b011,1'b1,MN,1'b0,4'h5},  // R3 mismatch
    {3'b001,1'b1,MN,1'b0,4'h5},
    {3'b111,1'b1,MN,1'b0,4'h5},
    {3'b001,1'b1,MN,1'b0,4'h5},
    {3'b111,1'b1,MS,1'b1,4'h6},  // R2
    {3'b011,1'b1,MF,1'b0,4'h6},  // R4
    {3'b111,1'b0,MS,1'b1,4'h3},  // R8 missed window
    {3'b101,1'b1,MN,1'b0,4'h3}
  };

  task automatic chk(string tag, logic [1:0] m, logic p, logic [3:0] s);
    total++;
    if (mode !== m || pulse !== p || src !== s) begin
      bad++;
      $display("FAIL %s: mode=%0d pulse=%0d src=%h expected mode=%0d pulse=%0d src=%h",
               tag, mode, pulse, src, m, p, s);
    end
  endtask

  // drive at a negedge, return at the next negedge with the result visible
  task automatic wr(logic [2:0] c, logic l);
    wr_valid = 1'b1; wr_code = c; wd_legal = l;
    @(negedge clk);
    wr_valid = 1'b0; wd_legal = 1'b0;
  endtask

  task automatic entry_seq();
    wr(3'b111, 1'b1);
    wr(3'b001, 1'b1);
    wr(3'b111, 1'b1);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    chk("R1 in reset", MS, 1'b0, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after reset", MS, 1'b0, 4'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][10:8], VEC[i][7]);
      chk($sformatf("table row %0d", i), VEC[i][6:5], VEC[i][4], VEC[i][3:0]);
    end

    // R13 single pulse, then R7 timeout count
    entry_seq();
    chk("R2 entry", MS, 1'b1, 4'h6);
    first = 0;
    for (int n = 1; n <= 3 * INIT; n++) begin
      @(negedge clk);
      if (n == 1) chk("R13 pulse one cycle", MS, 1'b0, 4'h6);
      if (pulse && first == 0) begin
        first = n;
        chk("R7 timeout source", MS, 1'b1, 4'h8);
        break;
      end
    end
    total++;
    if (first != INIT) begin
      bad++;
      $display("FAIL R7: timeout after %0d cycles expected %0d", first, INIT);
    end
    wr(3'b011, 1'b1);
    chk("R7 arming cleared", MS, 1'b0, 4'h8);

    // R8 overflow ignored in normal, acts in flash
    wr(3'b101, 1'b1);
    chk("R5", MN, 1'b0, 4'h8);
    wd_ovf = 1'b1; @(negedge clk); wd_ovf = 1'b0;
    chk("R8 overflow in normal ignored", MN, 1'b0, 4'h8);
    entry_seq();
    wr(3'b011, 1'b1);
    chk("R4", MF, 1'b0, 4'h6);
    wd_ovf = 1'b1; @(negedge clk); wd_ovf = 1'b0;
    chk("R8 overflow in flash", MS, 1'b1, 4'h3);

    // R11 / R12 fail-safe from flash
    wr(3'b101, 1'b1);
    entry_seq();
    wr(3'b011, 1'b1);
    chk("R4", MF, 1'b0, 4'h6);
    osc_fault = 1'b1; @(negedge clk);
    chk("R11 fault", MX, 1'b0, 4'h6);
    wake = 1'b1; @(negedge clk);
    chk("R12 wake during fault", MX, 1'b0, 4'h6);
    wake = 1'b0; osc_fault = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 healthy without wake", MX, 1'b0, 4'h6);
    wake = 1'b1; @(negedge clk); wake = 1'b0;
    chk("R12 wake exit", MS, 1'b1, 4'h9);
    wr(3'b011, 1'b1);
    chk("R11 arming cleared", MS, 1'b0, 4'h9);
    wr(3'b010, 1'b1);
    chk("R6 other code ignored", MS, 1'b0, 4'h9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule